// File: doc/BRIEF.md
# Ethernet MAC Transmit Frame Sequencer

This block is the main transmit control machine of an Ethernet MAC that works in half or full duplex. It reads a frame byte by byte from a show-ahead transmit FIFO. It sends the frame out as a byte-wide data stream with a data-valid strobe, in this order: preamble, start-of-frame delimiter, payload, zero padding, and a 32-bit frame check sequence. The serialiser that feeds the PHY pins, the DMA that fills the FIFO and the register bus are outside the block. The enable, halt and interrupt-enable controls come in as plain levels.

A frame starts only when transmission is enabled, no halt control is active, an external interpacket-gap timer reports that the gap has elapsed, and the FIFO holds enough bytes that the DMA has some room for latency. Each time a frame ends or is abandoned, the block pulses a start request to the gap timer. If a collision happens on the medium, the block rewinds the FIFO to the start of the frame and asks an external backoff timer to wait. It passes the attempt number to that timer. When the timer reports done, the block sends the same frame again, starting from the preamble. Three conditions make the block drop the frame, flush the FIFO and set a sticky status flag: a byte with bad parity, the FIFO running dry before the end-of-frame byte, and too many collided attempts.

Top module: `eth_tx_seq`

## Requirements
- R1: A frame starts only while `tx_enable_i` is 1, `halt_req_i`, `halt_now_i` and `halt_all_i` are all 0, and `gap_ready_i` is 1. Otherwise `tx_en_o` stays 0.
- R2: A frame does not start while `fifo_level_i` is below MIN_FILL (default 8). It starts once the level reaches MIN_FILL.
- R3: Every attempt begins with seven bytes of 0x55 and then one byte of 0xD5, each sent with `tx_en_o` high.
- R4: Payload bytes follow in FIFO order, one for each `fifo_rd_o` pulse. A byte is good when `fifo_par_i` equals the XOR of its eight data bits. The byte flagged by `fifo_eof_i` is the last payload byte.
- R5: A payload shorter than MIN_PAYLOAD bytes (default 60) is followed by 0x00 bytes until it reaches MIN_PAYLOAD. Longer payloads get no padding.
- R6: After the payload and padding, the block sends four FCS bytes. The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result inverted), sent least significant byte first. A CRC run over the payload, the padding and the FCS therefore leaves the fixed residue 0xC704DD7B when computed in MSB-first register form with each byte fed LSB first.
- R7: With the last FCS byte, `done_o` pulses for exactly one cycle. `irq_o` pulses in the same cycle only if `irq_en_i` is 1. `gap_start_o` pulses once per finished frame.
- R8: A byte with bad parity aborts the frame before that byte is sent. The block pulses `fifo_flush_o`, sets the sticky `st_parity_o`, and does not pulse `done_o`.
- R9: A collision while the frame is on the medium stops the output. The block pulses `fifo_rewind_o` and `bo_start_o`, with `bo_attempt_o` set to the number of collided attempts so far. After `bo_done_i`, it resends the whole frame from the preamble.
- R10: When the MAX_ATTEMPTS-th attempt (default 16) collides, the frame is dropped with no backoff. The block pulses `fifo_flush_o` and sets the sticky `st_excess_o`.
- R11: If the FIFO is empty before the end-of-frame byte has been read, the frame is aborted. The block pulses `fifo_flush_o`, sets the sticky `st_underrun_o`, and does not pulse `done_o`.
- R12: After reset, all outputs are 0 and all status flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable_i | input | 1 | Transmit enable level |
| halt_req_i | input | 1 | Transmit halt request level |
| halt_now_i | input | 1 | Immediate halt level |
| halt_all_i | input | 1 | General MAC halt level |
| irq_en_i | input | 1 | Completion interrupt enable |
| fifo_level_i | input | LVL_W | Bytes currently in the FIFO |
| fifo_empty_i | input | 1 | FIFO has no byte to show |
| fifo_data_i | input | 8 | Byte at the FIFO head |
| fifo_par_i | input | 1 | Parity bit of the head byte (XOR of its bits) |
| fifo_eof_i | input | 1 | Head byte is the last payload byte |
| fifo_rd_o | output | 1 | Pop the head byte |
| fifo_rewind_o | output | 1 | Return the read pointer to frame start |
| fifo_flush_o | output | 1 | Discard the frame in the FIFO |
| gap_ready_i | input | 1 | Interpacket gap has elapsed |
| gap_start_o | output | 1 | Start the gap timer |
| col_i | input | 1 | Collision detected on the medium |
| bo_start_o | output | 1 | Start the backoff timer |
| bo_attempt_o | output | CW | Collided attempt count for the backoff draw |
| bo_done_i | input | 1 | Backoff wait has finished |
| txd_o | output | 8 | Transmit byte |
| tx_en_o | output | 1 | Transmit byte valid |
| done_o | output | 1 | Frame completed (one cycle) |
| irq_o | output | 1 | Completion interrupt (one cycle) |
| st_parity_o | output | 1 | Sticky parity-abort flag |
| st_underrun_o | output | 1 | Sticky underrun flag |
| st_excess_o | output | 1 | Sticky excessive-collision flag |

## Verification
The bench builds the block with MIN_PAYLOAD = 16 and MAX_ATTEMPTS = 3, and keeps MIN_FILL at 8. This lets it sweep every payload length from 8 to 24. The sweep covers the padded region, the exact padding boundary and unpadded frames, and for each frame the bench checks the length, content and CRC residue. The small attempt limit puts the excessive-collision drop within reach after three collisions. The bench also runs collisions at early and late byte positions, the fill holdoff, each of the five blocking conditions on its own, a parity abort and an underrun.

// File: rtl/eth_tx_seq_pkg.sv
package eth_tx_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_DATA,
    S_PAD,
    S_FCS,
    S_BACKOFF
  } tx_state_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [7:0] PAD_BYTE = 8'h00;
  localparam int unsigned PRE_LEN = 8;

  // one byte through the reflected CRC-32 register, LSB first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // parity bit is the XOR of the data bits
  function automatic logic parity_good(input logic [7:0] d, input logic p);
    return (^d) == p;
  endfunction

  // FCS byte k of the inverted register, least significant byte first
  function automatic logic [7:0] fcs_pick(input logic [31:0] crc, input logic [1:0] k);
    logic [31:0] f;
    f = ~crc;
    return f[8*k +: 8];
  endfunction

endpackage

// File: rtl/eth_tx_fcs_reg.sv
module eth_tx_fcs_reg
  import eth_tx_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= '1;
    else if (en)        crc_q <= crc32_step(crc_q, din);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/eth_tx_retry_ctr.sv
module eth_tx_retry_ctr #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int CW = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  output logic [CW-1:0] next_n,
  output logic          at_limit
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (bump)     cnt_q <= cnt_q + 1'b1;
  end

  assign next_n   = cnt_q + 1'b1;
  assign at_limit = (next_n == CW'(MAX_ATTEMPTS));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_ATTEMPTS));
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_seq_pkg::*;
#(
  parameter int MIN_FILL     = 8,
  parameter int MIN_PAYLOAD  = 60,
  parameter int MAX_ATTEMPTS = 16,
  parameter int LVL_W        = 8,
  localparam int CW = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable_i,
  input  logic             halt_req_i,
  input  logic             halt_now_i,
  input  logic             halt_all_i,
  input  logic             irq_en_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             fifo_empty_i,
  input  logic [7:0]       fifo_data_i,
  input  logic             fifo_par_i,
  input  logic             fifo_eof_i,
  output logic             fifo_rd_o,
  output logic             fifo_rewind_o,
  output logic             fifo_flush_o,
  input  logic             gap_ready_i,
  output logic             gap_start_o,
  input  logic             col_i,
  output logic             bo_start_o,
  output logic [CW-1:0]    bo_attempt_o,
  input  logic             bo_done_i,
  output logic [7:0]       txd_o,
  output logic             tx_en_o,
  output logic             done_o,
  output logic             irq_o,
  output logic             st_parity_o,
  output logic             st_underrun_o,
  output logic             st_excess_o
);
  localparam int BW = $clog2(MIN_PAYLOAD + 1);
  localparam logic [BW-1:0] PAY_MIN = BW'(MIN_PAYLOAD);

  tx_state_e     state_q;
  logic [2:0]    idx_q;
  logic [BW-1:0] bcnt_q;
  logic [7:0]    txd_q;
  logic          tx_en_q, done_q, irq_q, flush_q, rewind_q, bo_start_q, gap_q;
  logic          st_par_q, st_und_q, st_exc_q;
  logic [CW-1:0] bo_att_q;

  // named events
  logic          start_ok, in_air, col_hit, byte_ok, par_bad, underrun;
  logic          finish, abort_any, drop;
  logic [BW-1:0] bcnt_inc;
  logic          crc_en, crc_init;
  logic [7:0]    crc_din;
  logic [31:0]   crc;
  logic [CW-1:0] next_n;
  logic          at_limit;

  assign start_ok = tx_enable_i && !halt_req_i && !halt_now_i && !halt_all_i &&
                    gap_ready_i && !fifo_empty_i &&
                    (fifo_level_i >= LVL_W'(MIN_FILL));
  assign in_air   = (state_q == S_PRE) || (state_q == S_DATA) ||
                    (state_q == S_PAD) || (state_q == S_FCS);
  assign col_hit  = in_air && col_i;
  assign byte_ok  = (state_q == S_DATA) && !col_i && !fifo_empty_i &&
                    parity_good(fifo_data_i, fifo_par_i);
  assign par_bad  = (state_q == S_DATA) && !col_i && !fifo_empty_i &&
                    !parity_good(fifo_data_i, fifo_par_i);
  assign underrun = (state_q == S_DATA) && !col_i && fifo_empty_i;
  assign finish   = (state_q == S_FCS) && !col_i && (idx_q == 3'd3);
  assign drop     = col_hit && at_limit;
  assign abort_any = par_bad || underrun || drop;
  assign bcnt_inc = (bcnt_q == PAY_MIN) ? bcnt_q : bcnt_q + 1'b1;

  assign crc_init = (state_q == S_PRE);
  assign crc_en   = byte_ok || ((state_q == S_PAD) && !col_i);
  assign crc_din  = (state_q == S_DATA) ? fifo_data_i : PAD_BYTE;

  eth_tx_fcs_reg u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .en    (crc_en),
    .din   (crc_din),
    .crc_o (crc)
  );

  eth_tx_retry_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .CW(CW)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (finish || abort_any),
    .bump     (col_hit && !at_limit),
    .next_n   (next_n),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  idx_q <= '0;  bcnt_q <= '0;  txd_q <= '0;
      tx_en_q <= 1'b0;  done_q <= 1'b0;  irq_q <= 1'b0;  flush_q <= 1'b0;
      rewind_q <= 1'b0;  bo_start_q <= 1'b0;  gap_q <= 1'b0;
      st_par_q <= 1'b0;  st_und_q <= 1'b0;  st_exc_q <= 1'b0;  bo_att_q <= '0;
    end else begin
      tx_en_q <= 1'b0;  done_q <= 1'b0;  irq_q <= 1'b0;  flush_q <= 1'b0;
      rewind_q <= 1'b0;  bo_start_q <= 1'b0;  gap_q <= 1'b0;
      if (col_hit) begin
        if (at_limit) begin
          st_exc_q <= 1'b1;  flush_q <= 1'b1;  gap_q <= 1'b1;  state_q <= S_IDLE;
        end else begin
          bo_start_q <= 1'b1;  rewind_q <= 1'b1;  bo_att_q <= next_n;
          state_q <= S_BACKOFF;
        end
      end else begin
        unique case (state_q)
          S_IDLE: if (start_ok) begin
            state_q <= S_PRE;  idx_q <= '0;
          end
          S_PRE: begin
            tx_en_q <= 1'b1;
            txd_q   <= (idx_q == 3'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
            idx_q   <= idx_q + 3'd1;
            if (idx_q == 3'(PRE_LEN - 1)) begin
              state_q <= S_DATA;  bcnt_q <= '0;
            end
          end
          S_DATA: begin
            if (underrun) begin
              st_und_q <= 1'b1;  flush_q <= 1'b1;  gap_q <= 1'b1;  state_q <= S_IDLE;
            end else if (par_bad) begin
              st_par_q <= 1'b1;  flush_q <= 1'b1;  gap_q <= 1'b1;  state_q <= S_IDLE;
            end else begin
              tx_en_q <= 1'b1;  txd_q <= fifo_data_i;  bcnt_q <= bcnt_inc;
              if (fifo_eof_i) begin
                state_q <= (bcnt_inc < PAY_MIN) ? S_PAD : S_FCS;
                idx_q   <= '0;
              end
            end
          end
          S_PAD: begin
            tx_en_q <= 1'b1;  txd_q <= PAD_BYTE;  bcnt_q <= bcnt_inc;
            if (bcnt_inc == PAY_MIN) begin
              state_q <= S_FCS;  idx_q <= '0;
            end
          end
          S_FCS: begin
            tx_en_q <= 1'b1;
            txd_q   <= fcs_pick(crc, idx_q[1:0]);
            idx_q   <= idx_q + 3'd1;
            if (finish) begin
              done_q <= 1'b1;  irq_q <= irq_en_i;  gap_q <= 1'b1;  state_q <= S_IDLE;
            end
          end
          S_BACKOFF: if (bo_done_i) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign fifo_rd_o     = byte_ok;
  assign fifo_rewind_o = rewind_q;
  assign fifo_flush_o  = flush_q;
  assign gap_start_o   = gap_q;
  assign bo_start_o    = bo_start_q;
  assign bo_attempt_o  = bo_att_q;
  assign txd_o         = txd_q;
  assign tx_en_o       = tx_en_q;
  assign done_o        = done_q;
  assign irq_o         = irq_q;
  assign st_parity_o   = st_par_q;
  assign st_underrun_o = st_und_q;
  assign st_excess_o   = st_exc_q;

  // R4
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |=> (tx_en_o && txd_o == $past(fifo_data_i)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  // R8
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_parity_o |=> st_parity_o);

  // R9
  backoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_start_o |=> !tx_en_o);
endmodule

// File: tb/eth_tx_seq_tb_top.sv
`timescale 1ns/1ps
module eth_tx_seq_tb_top;
  localparam int MINP = 16;
  localparam int MAXA = 3;
  localparam int CW   = $clog2(MAXA + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic tx_enable = 1'b1, halt_req = 1'b0, halt_now = 1'b0, halt_all = 1'b0;
  logic irq_en = 1'b0, gap_force = 1'b1;
  logic [7:0] fifo_level, fifo_data, txd;
  logic fifo_empty, fifo_par, fifo_eof, fifo_rd, fifo_rewind, fifo_flush;
  logic gap_ready, gap_start, col = 1'b0, bo_start, bo_done = 1'b0;
  logic [CW-1:0] bo_attempt;
  logic tx_en, done, irq, st_par, st_und, st_exc;

  // FIFO model
  logic [7:0] mem [0:63];
  int frame_len = 0, wr_cnt = 0, bad_idx = -1, load_tok = 0;
  int rd_ptr = 0, seen_tok = 0;
  logic dropped = 1'b0;

  assign fifo_empty = dropped || (seen_tok != load_tok) || (rd_ptr >= wr_cnt);
  assign fifo_level = fifo_empty ? 8'd0 : 8'(wr_cnt - rd_ptr);
  assign fifo_data  = mem[rd_ptr & 63];
  assign fifo_par   = (^mem[rd_ptr & 63]) ^ (rd_ptr == bad_idx);
  assign fifo_eof   = (rd_ptr == frame_len - 1);

  always @(posedge clk) begin
    if (seen_tok != load_tok) begin
      rd_ptr <= 0;  seen_tok <= load_tok;  dropped <= 1'b0;
    end else if (fifo_flush) begin
      rd_ptr <= 0;  dropped <= 1'b1;
    end else if (fifo_rewind) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end

  // monitor, gap timer, backoff timer, collision injector
  logic [7:0] cap [0:255];
  int cap_n = 0, att_start = 0, test_base = 0;
  int n_done = 0, n_irq = 0, n_flush = 0, n_gap = 0, n_bo = 0, bo_last = 0;
  int gap_cnt = 0, bo_cnt = 0, col_done = 0;
  int col_base = 0, col_want = 0, col_pos = 0;

  assign gap_ready = gap_force && (gap_cnt == 0);

  always @(negedge clk) begin
    int eff;
    eff = (att_start > test_base) ? att_start : test_base;
    col <= 1'b0;
    bo_done <= 1'b0;
    if (tx_en) begin
      if ((col_done - col_base) < col_want && (cap_n - eff) == col_pos) begin
        col <= 1'b1;  col_done <= col_done + 1;
      end
      cap[cap_n & 255] <= txd;
      cap_n <= cap_n + 1;
    end
    if (done) n_done <= n_done + 1;
    if (irq) n_irq <= n_irq + 1;
    if (fifo_flush) n_flush <= n_flush + 1;
    if (gap_start) begin n_gap <= n_gap + 1; gap_cnt <= 12; end
    else if (gap_cnt > 0) gap_cnt <= gap_cnt - 1;
    if (bo_start) begin
      n_bo <= n_bo + 1;  bo_last <= int'(bo_attempt);  att_start <= cap_n;  bo_cnt <= 6;
    end else if (bo_cnt > 0) begin
      bo_cnt <= bo_cnt - 1;
      if (bo_cnt == 1) bo_done <= 1'b1;
    end
  end

  eth_tx_seq #(.MIN_FILL(8), .MIN_PAYLOAD(MINP), .MAX_ATTEMPTS(MAXA), .LVL_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_enable_i(tx_enable), .halt_req_i(halt_req),
    .halt_now_i(halt_now), .halt_all_i(halt_all), .irq_en_i(irq_en),
    .fifo_level_i(fifo_level), .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
    .fifo_par_i(fifo_par), .fifo_eof_i(fifo_eof), .fifo_rd_o(fifo_rd),
    .fifo_rewind_o(fifo_rewind), .fifo_flush_o(fifo_flush), .gap_ready_i(gap_ready),
    .gap_start_o(gap_start), .col_i(col), .bo_start_o(bo_start),
    .bo_attempt_o(bo_attempt), .bo_done_i(bo_done), .txd_o(txd), .tx_en_o(tx_en),
    .done_o(done), .irq_o(irq), .st_parity_o(st_par), .st_underrun_o(st_und),
    .st_excess_o(st_exc)
  );

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;
  int d0, i0, f0, g0, b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int l, input int i);
    return 8'(l * 7 + i * 13 + 1);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input int l, input int w, input int bad, input int nc,
                      input int cp, input bit ie, input int wait_cyc);
    @(negedge clk);
    for (int i = 0; i < l; i++) mem[i] = pat(l, i);
    frame_len = l;  wr_cnt = w;  bad_idx = bad;  irq_en = ie;
    col_base = col_done;  col_want = nc;  col_pos = cp;
    d0 = n_done;  i0 = n_irq;  f0 = n_flush;  g0 = n_gap;  b0 = n_bo;
    test_base = cap_n;
    load_tok = load_tok + 1;
    repeat (wait_cyc) @(negedge clk);
  endtask

  function automatic int att_first();
    return (att_start > test_base) ? att_start : test_base;
  endfunction

  task automatic verify_good(input int l, input bit ie, input int nc);
    int e, nb, exp_len, plen;
    bit ok;
    logic [31:0] c;
    logic [7:0] b;
    e = att_first();
    nb = cap_n - e;
    plen = (l < MINP) ? MINP : l;
    exp_len = 8 + plen + 4;
    chk(nb == exp_len, "R5 frame length", nb, exp_len);
    ok = 1'b1;
    for (int k = 0; k < 8; k++)
      if (cap[(e + k) & 255] != ((k == 7) ? 8'hD5 : 8'h55)) ok = 1'b0;
    chk(ok, "R3 preamble/SFD", int'(cap[(e + 7) & 255]), 'hD5);
    ok = 1'b1;
    for (int k = 0; k < l; k++)
      if (cap[(e + 8 + k) & 255] != pat(l, k)) ok = 1'b0;
    chk(ok, "R4 payload bytes", int'(cap[(e + 8) & 255]), int'(pat(l, 0)));
    ok = 1'b1;
    for (int k = l; k < plen; k++)
      if (cap[(e + 8 + k) & 255] != 8'h00) ok = 1'b0;
    chk(ok, "R5 pad bytes zero", 0, 0);
    c = 32'hFFFFFFFF;
    for (int k = 8; k < nb; k++) begin
      b = cap[(e + k) & 255];
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[31] ^ b[j];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    chk(c == 32'hC704DD7B, "R6 FCS residue", int'(c), 'hC704DD7B);
    chk(n_done - d0 == 1, "R7 done pulses", n_done - d0, 1);
    chk(n_irq - i0 == int'(ie), "R7 irq pulses", n_irq - i0, int'(ie));
    chk(n_gap - g0 == 1, "R7 gap_start pulses", n_gap - g0, 1);
    chk(n_bo - b0 == nc, "R9 backoff starts", n_bo - b0, nc);
    if (nc > 0) chk(bo_last == nc, "R9 attempt number", bo_last, nc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;  n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R12 reset state
    chk(!tx_en && !done && !irq && !bo_start && !fifo_flush, "R12 outputs idle", int'(tx_en), 0);
    chk(!st_par && !st_und && !st_exc, "R12 status clear", int'({st_par, st_und, st_exc}), 0);

    // R5 R6 sweep of payload lengths across the pad boundary
    for (int l = 8; l <= 24; l++) begin
      load(l, l, -1, 0, 0, l[0], 150);
      verify_good(l, l[0], 0);
    end

    // R2 fill holdoff
    load(20, 5, -1, 0, 0, 1'b0, 80);
    chk(cap_n == test_base, "R2 no start below fill", cap_n - test_base, 0);
    @(negedge clk); wr_cnt = 20;
    repeat (150) @(negedge clk);
    verify_good(20, 1'b0, 0);

    // R1 each blocking control alone
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      tx_enable = (c != 0);  halt_req = (c == 1);  halt_now = (c == 2);
      halt_all = (c == 3);  gap_force = (c != 4);
      load(12, 12, -1, 0, 0, 1'b1, 80);
      chk(cap_n == test_base, "R1 blocked start", cap_n - test_base, 0);
      tx_enable = 1'b1;  halt_req = 1'b0;  halt_now = 1'b0;  halt_all = 1'b0;  gap_force = 1'b1;
      repeat (150) @(negedge clk);
      verify_good(12, 1'b1, 0);
    end

    // R9 collisions at several byte positions
    load(10, 10, -1, 1, 3, 1'b0, 300);
    verify_good(10, 1'b0, 1);
    load(22, 22, -1, 2, 20, 1'b1, 400);
    verify_good(22, 1'b1, 2);
    load(14, 14, -1, 1, 0, 1'b0, 300);
    verify_good(14, 1'b0, 1);

    // R10 excessive collisions
    do_reset();
    load(18, 18, -1, MAXA, 2, 1'b0, 400);
    chk(st_exc == 1'b1, "R10 excess flag", int'(st_exc), 1);
    chk(n_bo - b0 == MAXA - 1, "R10 backoffs before drop", n_bo - b0, MAXA - 1);
    chk(n_flush - f0 == 1, "R10 flush", n_flush - f0, 1);
    chk(n_done - d0 == 0, "R10 no done", n_done - d0, 0);

    // R8 parity abort
    do_reset();
    load(20, 20, 5, 0, 0, 1'b0, 300);
    chk(st_par == 1'b1, "R8 parity flag", int'(st_par), 1);
    chk(cap_n - test_base == 13, "R8 bytes before abort", cap_n - test_base, 13);
    chk(n_flush - f0 == 1, "R8 flush", n_flush - f0, 1);
    chk(n_done - d0 == 0 && !st_und, "R8 no done", n_done - d0, 0);

    // R11 underrun
    do_reset();
    load(20, 12, -1, 0, 0, 1'b0, 300);
    chk(st_und == 1'b1, "R11 underrun flag", int'(st_und), 1);
    chk(cap_n - test_base == 20, "R11 bytes before abort", cap_n - test_base, 20);
    chk(n_flush - f0 == 1, "R11 flush", n_flush - f0, 1);
    chk(n_done - d0 == 0 && !st_par, "R11 no done", n_done - d0, 0);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule